// File: doc/BRIEF.md
# Circuit Path Reservation Controller

This block is the control unit of one router in a circuit-switched mesh. Small control flits travel on a separate packet network. A setup flit reserves a connection from one input port to one output port of the router's data switch. A teardown flit later arms a countdown, and the connection is freed when the countdown runs out. Acknowledgements travel in the opposite direction along the reserved path. The block drives the enable bits of the data switch from its table of reserved connections.

The router has five ports: north (0), east (1), south (2), west (3) and local (4). Each port has a forward control channel and a backward control channel. The forward channel carries setup and teardown flits along the direction of the circuit. On port p, the backward input comes from the neighbour behind output p. On port p, the backward output goes to the neighbour in front of input p. The router's mesh size and its own coordinates are parameters. A router on the mesh border drops the ports that would leave the mesh, so it works as a four-port edge router or a three-port corner router. Y grows toward north and X grows toward east.

Top module: `circuit_resv_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, every forward and backward output valid is low and `sw_en` is zero.
- R2: A forward flit is packed MSB first as {kind (1 = teardown, 0 = setup), dst_x[2:0], dst_y[2:0], ttl[11:0]}. An accepted setup picks its output by comparing the destination with the router position, X first and then Y. A larger X goes east, a smaller X goes west. A larger Y goes north, a smaller Y goes south. When both coordinates match, it goes local. The flit leaves unchanged on that output's forward channel after the next clock edge.
- R3: A setup is accepted only when three conditions hold: its output exists, no input owns that output, and its input owns no other output. Among setups that reach the same free output in one cycle, the lowest port index wins. Every refused setup returns a backward flit with nack = 1 on its own input port after the next edge.
- R4: Bit o*5+i of `sw_en` is high exactly while input i owns output o. The exception is the straight pairs: north with south and east with west, in either direction. Their bits stay zero.
- R5: A teardown that arrives on an input owning output o leaves on o after the next edge, with ttl lowered by one and held at zero. A teardown on an input that owns nothing produces no output.
- R6: A teardown with ttl T > 0 taken at edge k keeps the connection through edge k+T-1. The connection is freed at edge k+T. A teardown with T = 0 frees it at edge k. A new teardown reloads the count.
- R7: A backward flit with nack = 0 arriving on output port o is passed to the backward output of the input owning o after the next edge. A backward flit on an unowned port is dropped.
- R8: A backward flit with nack = 1 on an owned output is passed back in the same way. It also frees that output at the same edge.
- R9: Suppose a passed-back flit and a locally made refusal target the same backward output in one cycle. The passed-back flit is sent and the refusal is discarded.
- R10: A port that would leave the mesh is absent. Flits on its inputs are ignored, and its outputs stay low. A setup routed toward it is refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fwd_in_valid | input | 5 | Forward flit present, one bit per port |
| fwd_in_flit | input | 95 | Forward flits, port p at bits p*19 +: 19 |
| fwd_out_valid | output | 5 | Forward flit sent, one bit per output port |
| fwd_out_flit | output | 95 | Forward flits sent, same layout |
| bwd_in_valid | input | 5 | Backward flit arriving on output port p |
| bwd_in_nack | input | 5 | Backward flit is a refusal |
| bwd_out_valid | output | 5 | Backward flit sent toward input port p's upstream |
| bwd_out_nack | output | 5 | Sent backward flit is a refusal |
| sw_en | output | 25 | Data switch enables, bit o*5+i for input i to output o |

## Verification
A corrupt owner entry shows up at once in `sw_en`, one cycle after the edge that wrote it. It also shows up later as the wrong acceptance or refusal of the next setup aimed at that output. A countdown that is off by one cycle moves the falling edge of the enable bit by one cycle. So the bench samples the enable bit on each cycle around the expected release, not only at the end. Wrong routing or a wrong priority choice appears in the very next cycle, as a forward flit on the wrong port or a refusal on the wrong port.

// File: rtl/rsv_pkg.sv
package rsv_pkg;

    localparam int NP      = 5;
    localparam int COORD_W = 3;
    localparam int TTL_W   = 12;
    localparam int FLIT_W  = 1 + 2 * COORD_W + TTL_W;

    typedef enum logic [2:0] {
        P_N = 3'd0,
        P_E = 3'd1,
        P_S = 3'd2,
        P_W = 3'd3,
        P_L = 3'd4
    } port_e;

    typedef struct packed {
        logic               tear;
        logic [COORD_W-1:0] dx;
        logic [COORD_W-1:0] dy;
        logic [TTL_W-1:0]   ttl;
    } flit_t;

    // pass-through pairs need no switching element
    function automatic logic is_straight(input int i, input int o);
        return (i < 4) && (o < 4) && ((i ^ 2) == o);
    endfunction

    function automatic logic [NP*NP-1:0] straight_mask();
        logic [NP*NP-1:0] m;
        m = '0;
        for (int o = 0; o < NP; o++)
            for (int i = 0; i < NP; i++)
                if (is_straight(i, o)) m[o*NP+i] = 1'b1;
        return m;
    endfunction

    function automatic logic [NP-1:0] present_mask(input int x, input int y,
                                                   input int w, input int h);
        logic [NP-1:0] m;
        m        = '0;
        m[P_N]   = (y < h - 1);
        m[P_E]   = (x < w - 1);
        m[P_S]   = (y > 0);
        m[P_W]   = (x > 0);
        m[P_L]   = 1'b1;
        return m;
    endfunction

    function automatic logic [TTL_W-1:0] ttl_dec(input logic [TTL_W-1:0] t);
        return (t == '0) ? '0 : t - 1'b1;
    endfunction

endpackage

// File: rtl/rsv_route.sv
module rsv_route
    import rsv_pkg::*;
#(
    parameter int MY_X = 0,
    parameter int MY_Y = 0
) (
    input  logic [COORD_W-1:0] dst_x,
    input  logic [COORD_W-1:0] dst_y,
    output port_e              dir
);
    localparam logic [COORD_W-1:0] HX = COORD_W'(MY_X);
    localparam logic [COORD_W-1:0] HY = COORD_W'(MY_Y);

    always_comb begin
        if (dst_x > HX)      dir = P_E;
        else if (dst_x < HX) dir = P_W;
        else if (dst_y > HY) dir = P_N;
        else if (dst_y < HY) dir = P_S;
        else                 dir = P_L;
    end
endmodule

// File: rtl/rsv_hold_timer.sv
module rsv_hold_timer
    import rsv_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [TTL_W-1:0] load_val,
    input  logic             cancel,
    output logic             expire
);
    logic             armed;
    logic [TTL_W-1:0] cnt;

    always_comb begin
        if (cancel)    expire = 1'b0;
        else if (load) expire = (load_val == '0);
        else           expire = armed && (cnt == TTL_W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= 1'b0;
            cnt   <= '0;
        end else if (cancel) begin
            armed <= 1'b0;
        end else if (load) begin
            armed <= (load_val != '0);
            cnt   <= load_val;
        end else if (armed) begin
            if (cnt == TTL_W'(1)) armed <= 1'b0;
            cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/circuit_resv_ctrl.sv
module circuit_resv_ctrl
    import rsv_pkg::*;
#(
    parameter int MESH_W = 4,
    parameter int MESH_H = 4,
    parameter int MY_X   = 1,
    parameter int MY_Y   = 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NP-1:0]        fwd_in_valid,
    input  logic [NP*FLIT_W-1:0] fwd_in_flit,
    output logic [NP-1:0]        fwd_out_valid,
    output logic [NP*FLIT_W-1:0] fwd_out_flit,
    input  logic [NP-1:0]        bwd_in_valid,
    input  logic [NP-1:0]        bwd_in_nack,
    output logic [NP-1:0]        bwd_out_valid,
    output logic [NP-1:0]        bwd_out_nack,
    output logic [NP*NP-1:0]     sw_en
);
    localparam logic [NP-1:0] PRESENT = present_mask(MY_X, MY_Y, MESH_W, MESH_H);

    flit_t         fin      [NP];
    port_e         route    [NP];
    logic [NP-1:0] owner_q  [NP];   // owner_q[o][i]: input i holds output o
    logic [NP-1:0] grant    [NP];
    flit_t         out_fl   [NP];
    logic [NP-1:0] tear_hit;
    logic [TTL_W-1:0] tear_ttl [NP];
    logic [NP-1:0] in_busy, nack_loc, relay_v, relay_n, nack_rel, expire;

    genvar g, h;
    generate
        for (g = 0; g < NP; g++) begin : g_port
            assign fin[g] = fwd_in_flit[g*FLIT_W +: FLIT_W];
            rsv_route #(.MY_X(MY_X), .MY_Y(MY_Y)) u_route (
                .dst_x(fin[g].dx), .dst_y(fin[g].dy), .dir(route[g]));
            rsv_hold_timer u_timer (
                .clk(clk), .rst(rst), .load(tear_hit[g]), .load_val(tear_ttl[g]),
                .cancel(nack_rel[g]), .expire(expire[g]));
            for (h = 0; h < NP; h++) begin : g_en
                if (is_straight(h, g)) begin : g_dark
                    assign sw_en[g*NP+h] = 1'b0;
                end else begin : g_lit
                    assign sw_en[g*NP+h] = owner_q[g][h];
                end
            end
        end
    endgenerate

    // forward channel: setup acceptance and teardown lookup
    always_comb begin
        in_busy = '0;
        for (int o = 0; o < NP; o++) in_busy |= owner_q[o];
        nack_loc = '0;
        tear_hit = '0;
        for (int o = 0; o < NP; o++) begin
            grant[o]    = '0;
            out_fl[o]   = '0;
            tear_ttl[o] = '0;
        end
        for (int i = 0; i < NP; i++) begin
            if (PRESENT[i] && fwd_in_valid[i]) begin
                if (!fin[i].tear) begin
                    if (PRESENT[route[i]] && owner_q[route[i]] == '0 &&
                        grant[route[i]] == '0 && !in_busy[i]) begin
                        grant[route[i]][i] = 1'b1;
                        out_fl[route[i]]   = fin[i];
                    end else begin
                        nack_loc[i] = 1'b1;
                    end
                end else begin
                    for (int o = 0; o < NP; o++) begin
                        if (owner_q[o][i]) begin
                            tear_hit[o]   = 1'b1;
                            tear_ttl[o]   = fin[i].ttl;
                            out_fl[o]     = fin[i];
                            out_fl[o].ttl = ttl_dec(fin[i].ttl);
                        end
                    end
                end
            end
        end
    end

    // backward channel: relay toward the owning input
    always_comb begin
        relay_v  = '0;
        relay_n  = '0;
        nack_rel = '0;
        for (int o = 0; o < NP; o++) begin
            if (PRESENT[o] && bwd_in_valid[o] && owner_q[o] != '0) begin
                nack_rel[o] = bwd_in_nack[o];
                for (int i = 0; i < NP; i++) begin
                    if (owner_q[o][i]) begin
                        relay_v[i] = 1'b1;
                        relay_n[i] = bwd_in_nack[o];
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int o = 0; o < NP; o++) owner_q[o] <= '0;
            fwd_out_valid <= '0;
            fwd_out_flit  <= '0;
            bwd_out_valid <= '0;
            bwd_out_nack  <= '0;
        end else begin
            for (int o = 0; o < NP; o++) begin
                if (grant[o] != '0)              owner_q[o] <= grant[o];
                else if (expire[o] || nack_rel[o]) owner_q[o] <= '0;
                fwd_out_valid[o] <= (grant[o] != '0) || tear_hit[o];
                fwd_out_flit[o*FLIT_W +: FLIT_W] <= out_fl[o];
            end
            bwd_out_valid <= relay_v | nack_loc;
            bwd_out_nack  <= relay_v ? relay_n : 'x;
            for (int i = 0; i < NP; i++)
                bwd_out_nack[i] <= relay_v[i] ? relay_n[i] : nack_loc[i];
        end
    end
endmodule

// File: rtl/rsv_checker.sv
module rsv_checker
    import rsv_pkg::*;
#(
    parameter int MESH_W = 4,
    parameter int MESH_H = 4,
    parameter int MY_X   = 1,
    parameter int MY_Y   = 1
) (
    input logic             clk,
    input logic             rst,
    input logic [NP-1:0]    fwd_in_valid,
    input logic [NP-1:0]    bwd_in_valid,
    input logic [NP-1:0]    fwd_out_valid,
    input logic [NP-1:0]    bwd_out_valid,
    input logic [NP*NP-1:0] sw_en,
    input logic [NP-1:0]    owner_q [NP]
);
    localparam logic [NP-1:0]    PRESENT = present_mask(MY_X, MY_Y, MESH_W, MESH_H);
    localparam logic [NP*NP-1:0] STRAIGHT = straight_mask();

    logic [NP-1:0] col [NP];
    always_comb begin
        for (int i = 0; i < NP; i++)
            for (int o = 0; o < NP; o++)
                col[i][o] = owner_q[o][i];
    end

    genvar g;
    generate
        for (g = 0; g < NP; g++) begin : g_chk
            // R3: one input per output
            a_r3_owner_onehot: assert property (@(posedge clk) disable iff (rst)
                $onehot0(owner_q[g]))
                else $error("owner of output %0d not one-hot", g);
            // R3: one output per input
            a_r3_input_single: assert property (@(posedge clk) disable iff (rst)
                $countones(col[g]) <= 1)
                else $error("input %0d holds several outputs", g);
        end
    endgenerate

    a_r10_absent_quiet: assert property (@(posedge clk) disable iff (rst)
        ((fwd_out_valid | bwd_out_valid) & ~PRESENT) == '0)
        else $error("absent port driven");

    a_r4_straight_dark: assert property (@(posedge clk) disable iff (rst)
        (sw_en & STRAIGHT) == '0)
        else $error("straight pair enabled");

    a_r4_enable_rise: assert property (@(posedge clk) disable iff (rst)
        ((sw_en & ~$past(sw_en)) != '0) |-> $past(|(fwd_in_valid & PRESENT)))
        else $error("enable rose without setup");

    a_r2_fwd_cause: assert property (@(posedge clk) disable iff (rst)
        (|fwd_out_valid) |-> $past(|(fwd_in_valid & PRESENT)))
        else $error("forward flit without input");

    a_r7_bwd_cause: assert property (@(posedge clk) disable iff (rst)
        (|bwd_out_valid) |-> $past((|(fwd_in_valid & PRESENT)) || (|(bwd_in_valid & PRESENT))))
        else $error("backward flit without cause");
endmodule

bind circuit_resv_ctrl rsv_checker #(
    .MESH_W(MESH_W), .MESH_H(MESH_H), .MY_X(MY_X), .MY_Y(MY_Y)
) chk_i (
    .clk(clk), .rst(rst),
    .fwd_in_valid(fwd_in_valid), .bwd_in_valid(bwd_in_valid),
    .fwd_out_valid(fwd_out_valid), .bwd_out_valid(bwd_out_valid),
    .sw_en(sw_en), .owner_q(owner_q)
);

// File: tb/circuit_resv_ctrl_tb_top.sv
module circuit_resv_ctrl_tb_top;
    import rsv_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic [NP-1:0]        fv = '0, bv = '0, bn = '0;
    logic [NP*FLIT_W-1:0] ff = '0;
    logic [NP-1:0]        fov, bov, bon;
    logic [NP*FLIT_W-1:0] fof;
    logic [NP*NP-1:0]     sw;

    logic [NP-1:0]        c_fv = '0, c_bv = '0, c_bn = '0;
    logic [NP*FLIT_W-1:0] c_ff = '0;
    logic [NP-1:0]        c_fov, c_bov, c_bon;
    logic [NP*FLIT_W-1:0] c_fof;
    logic [NP*NP-1:0]     c_sw;

    circuit_resv_ctrl dut_i (
        .clk(clk), .rst(rst), .fwd_in_valid(fv), .fwd_in_flit(ff),
        .fwd_out_valid(fov), .fwd_out_flit(fof), .bwd_in_valid(bv), .bwd_in_nack(bn),
        .bwd_out_valid(bov), .bwd_out_nack(bon), .sw_en(sw));

    circuit_resv_ctrl #(.MY_X(3), .MY_Y(3)) dut_corner_i (
        .clk(clk), .rst(rst), .fwd_in_valid(c_fv), .fwd_in_flit(c_ff),
        .fwd_out_valid(c_fov), .fwd_out_flit(c_fof), .bwd_in_valid(c_bv), .bwd_in_nack(c_bn),
        .bwd_out_valid(c_bov), .bwd_out_nack(c_bon), .sw_en(c_sw));

    int checks = 0, fails = 0;

    // reference state for dut_i at (1,1)
    int m_own [NP];
    int m_cnt [NP];
    bit m_arm [NP];
    logic [NP-1:0]        e_fov, e_bov, e_bon;
    logic [NP*FLIT_W-1:0] e_fof;
    logic [NP*NP-1:0]     e_sw;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [FLIT_W-1:0] mk(input bit tear, input int x, input int y, input int t);
        return {tear, 3'(x), 3'(y), 12'(t)};
    endfunction

    function automatic int dor(input int x, input int y);
        if (x > 1) return 1;
        if (x < 1) return 3;
        if (y > 1) return 0;
        if (y < 1) return 2;
        return 4;
    endfunction

    function automatic bit straight(input int i, input int o);
        return (i < 4) && (o < 4) && ((i ^ 2) == o);
    endfunction

    task automatic model_step();
        bit busy [NP]; bit taken [NP]; bit rel [NP]; bit ld [NP];
        bit nl [NP]; bit rv [NP]; bit rn [NP];
        logic [FLIT_W-1:0] fl;
        int r, t;
        e_fov = '0; e_fof = '0; e_bov = '0; e_bon = '0;
        for (int k = 0; k < NP; k++) begin
            busy[k] = 0; taken[k] = 0; rel[k] = 0; ld[k] = 0; nl[k] = 0; rv[k] = 0; rn[k] = 0;
        end
        for (int o = 0; o < NP; o++) if (m_own[o] >= 0) busy[m_own[o]] = 1;
        for (int i = 0; i < NP; i++) begin
            if (fv[i]) begin
                fl = ff[i*FLIT_W +: FLIT_W];
                if (!fl[FLIT_W-1]) begin
                    r = dor(int'(fl[17:15]), int'(fl[14:12]));
                    if (m_own[r] < 0 && !taken[r] && !busy[i]) begin
                        taken[r] = 1; e_fov[r] = 1'b1; e_fof[r*FLIT_W +: FLIT_W] = fl;
                    end else nl[i] = 1;
                end else begin
                    for (int o = 0; o < NP; o++) begin
                        if (m_own[o] == i) begin
                            t = int'(fl[11:0]);
                            e_fov[o] = 1'b1;
                            e_fof[o*FLIT_W +: FLIT_W] = {fl[18:12], 12'(t > 0 ? t - 1 : 0)};
                            ld[o] = 1;
                            if (t == 0) begin rel[o] = 1; m_arm[o] = 0; end
                            else begin m_cnt[o] = t; m_arm[o] = 1; end
                        end
                    end
                end
            end
        end
        for (int o = 0; o < NP; o++) begin
            if (!ld[o] && m_arm[o]) begin
                if (m_cnt[o] == 1) begin rel[o] = 1; m_arm[o] = 0; end
                else m_cnt[o]--;
            end
        end
        for (int o = 0; o < NP; o++) begin
            if (bv[o] && m_own[o] >= 0) begin
                rv[m_own[o]] = 1; rn[m_own[o]] = bn[o];
                if (bn[o]) begin rel[o] = 1; m_arm[o] = 0; end
            end
        end
        for (int i = 0; i < NP; i++) begin
            if (rv[i]) begin e_bov[i] = 1'b1; e_bon[i] = rn[i]; end
            else if (nl[i]) begin e_bov[i] = 1'b1; e_bon[i] = 1'b1; end
        end
        for (int o = 0; o < NP; o++) if (rel[o]) m_own[o] = -1;
        for (int i = 0; i < NP; i++) if (taken[i]) ;
        for (int i = 0; i < NP; i++) begin
            if (fv[i] && !ff[i*FLIT_W + FLIT_W-1] && !nl[i])
                m_own[dor(int'(ff[i*FLIT_W+15 +: 3]), int'(ff[i*FLIT_W+12 +: 3]))] = i;
        end
        e_sw = '0;
        for (int o = 0; o < NP; o++)
            if (m_own[o] >= 0 && !straight(m_own[o], o)) e_sw[o*NP + m_own[o]] = 1'b1;
    endtask

    // one clock with model compare; inputs were set at the preceding negedge
    task automatic cycle(input string tf, input string tb_, input string ts);
        model_step();
        @(posedge clk);
        @(negedge clk);
        chk({fov, fof} === {e_fov, e_fof}, tf, "forward", 128'({fov, fof}), 128'({e_fov, e_fof}));
        chk({bov, bon} === {e_bov, e_bon}, tb_, "backward", 128'({bov, bon}), 128'({e_bov, e_bon}));
        chk(sw === e_sw, ts, "sw_en", 128'(sw), 128'(e_sw));
        fv = '0; bv = '0; bn = '0;
    endtask

    task automatic put(input int p, input logic [FLIT_W-1:0] f);
        fv[p] = 1'b1; ff[p*FLIT_W +: FLIT_W] = f;
    endtask

    task automatic ctick();
        @(posedge clk); @(negedge clk);
    endtask

    initial begin
        #(20 * 150000);
        fails++;
        $display("FAIL watchdog R1 actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int o = 0; o < NP; o++) begin m_own[o] = -1; m_cnt[o] = 0; m_arm[o] = 0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(fov == '0 && bov == '0 && sw == '0, "R1", "after reset", 128'({fov, bov, sw}), 128'(0));
        chk(c_fov == '0 && c_bov == '0 && c_sw == '0, "R1", "corner after reset",
            128'({c_fov, c_bov, c_sw}), 128'(0));

        // R10 corner router at (3,3): east input absent
        c_fv[1] = 1'b1; c_ff[1*FLIT_W +: FLIT_W] = mk(0, 0, 3, 0);
        ctick(); c_fv = '0;
        chk(c_fov == '0 && c_bov == '0, "R10", "absent input ignored", 128'({c_fov, c_bov}), 128'(0));
        // R10 setup routed east from corner is refused
        c_fv[4] = 1'b1; c_ff[4*FLIT_W +: FLIT_W] = mk(0, 5, 3, 0);
        ctick(); c_fv = '0;
        chk(c_bov == 5'b10000 && c_bon == 5'b10000 && c_fov == '0, "R10", "absent output refusal",
            128'({c_fov, c_bov, c_bon}), 128'({5'b0, 5'b10000, 5'b10000}));
        // R2 corner routes south
        c_fv[4] = 1'b1; c_ff[4*FLIT_W +: FLIT_W] = mk(0, 3, 0, 0);
        ctick(); c_fv = '0;
        chk(c_fov == 5'b00100 && c_sw[2*5+4], "R2", "corner south grant",
            128'({c_fov, c_sw}), 128'({5'b00100, 25'(1) << 14}));

        // R2 local setup toward east
        put(4, mk(0, 3, 1, 0)); cycle("R2", "R3", "R4");
        chk(fov == 5'b00010 && sw[1*5+4], "R2", "east grant", 128'({fov, sw}), 128'({5'b00010, 25'(1) << 9}));
        // R3 east busy -> refusal on north
        put(0, mk(0, 3, 2, 0)); cycle("R3", "R3", "R3");
        chk(bov == 5'b00001 && bon == 5'b00001, "R3", "busy refusal", 128'({bov, bon}), 128'({5'd1, 5'd1}));
        // R5 teardown ttl 3
        put(4, mk(1, 3, 1, 3)); cycle("R5", "R5", "R6");
        chk(fof[1*FLIT_W +: 12] == 12'd2, "R5", "ttl lowered", 128'(fof[1*FLIT_W +: 12]), 128'(2));
        cycle("R6", "R6", "R6");
        chk(sw[9] == 1'b1, "R6", "held k+1", 128'(sw[9]), 128'(1));
        cycle("R6", "R6", "R6");
        chk(sw[9] == 1'b1, "R6", "held k+2", 128'(sw[9]), 128'(1));
        cycle("R6", "R6", "R6");
        chk(sw[9] == 1'b0, "R6", "freed k+3", 128'(sw[9]), 128'(0));
        // R3 contention: north and south both want east, north wins
        put(0, mk(0, 3, 1, 0)); put(2, mk(0, 2, 0, 0)); cycle("R3", "R3", "R3");
        chk(sw[1*5+0] && bov == 5'b00100, "R3", "lowest index wins", 128'({sw[5], bov}), 128'({1'b1, 5'b00100}));
        // R6 ttl zero frees at once
        put(0, mk(1, 0, 0, 0)); cycle("R6", "R6", "R6");
        chk(sw == '0, "R6", "ttl zero release", 128'(sw), 128'(0));
        // R4 straight west->east stays dark
        put(3, mk(0, 2, 1, 0)); cycle("R4", "R4", "R4");
        chk(fov == 5'b00010 && sw == '0, "R4", "straight dark", 128'({fov, sw}), 128'({5'b00010, 25'd0}));
        put(3, mk(1, 0, 0, 0)); cycle("R6", "R6", "R6");
        // R7 ack relay and drop
        put(4, mk(0, 1, 3, 0)); cycle("R7", "R7", "R7");
        bv[0] = 1'b1; cycle("R7", "R7", "R7");
        chk(bov == 5'b10000 && bon == '0, "R7", "ack relay", 128'({bov, bon}), 128'({5'b10000, 5'd0}));
        bv[2] = 1'b1; cycle("R7", "R7", "R7");
        chk(bov == '0, "R7", "unowned dropped", 128'(bov), 128'(0));
        // R8 nack relay frees north
        bv[0] = 1'b1; bn[0] = 1'b1; cycle("R8", "R8", "R8");
        chk(bov == 5'b10000 && bon == 5'b10000 && sw[4] == 1'b0, "R8", "nack relay release",
            128'({bov, bon, sw[4]}), 128'({5'b10000, 5'b10000, 1'b0}));
        // R9 relay beats local refusal
        put(4, mk(0, 1, 3, 0)); cycle("R9", "R9", "R9");
        bv[0] = 1'b1; put(4, mk(0, 0, 1, 0)); cycle("R9", "R9", "R9");
        chk(bov == 5'b10000 && bon == '0, "R9", "relay priority", 128'({bov, bon}), 128'({5'b10000, 5'd0}));
        // R5 stray teardown dropped
        put(1, mk(1, 0, 0, 7)); cycle("R5", "R5", "R5");
        chk(fov == '0, "R5", "stray teardown", 128'(fov), 128'(0));

        // random phase
        for (int n = 0; n < 4000; n++) begin
            for (int p = 0; p < NP; p++) begin
                if ($urandom % 5 == 0)
                    put(p, mk(($urandom % 3) == 0, $urandom % 4, $urandom % 4, $urandom % 10));
                if ($urandom % 8 == 0) begin
                    bv[p] = 1'b1; bn[p] = ($urandom % 3) == 0;
                end
            end
            cycle("R2", "R7", "R4");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule